// File: doc/BRIEF.md
# Address Claim Decoder for Base Register Windows

This block decides whether an incoming request address belongs to the device. Software places each of the device's regions by writing base registers; the sizes and kinds of those regions are fixed at elaboration by parameters. For each request the decoder compares the address with every programmed window and reports whether the device owns it. A claimed request comes back with the number of the winning window and the byte offset into it. An unclaimed request raises a no-match flag, which the surrounding logic turns into an unsupported-request reply.

The slots can hold four kinds of window. A 32-bit memory window lives below 4 GB. A 64-bit memory window is built from an even slot and the slot after it, which supplies address bits [63:32]. An I/O window and an empty slot are the other two kinds. A separate option-ROM register adds one more memory window, with its own enable in bit 0. The command-register memory and I/O enables gate their kinds of window. The result is registered and appears one cycle after the request strobe.

Top module: `addr_claim_decoder`

## Requirements
- R1: A memory request (req_is_io=0) is claimed by a memory window or the ROM window only while cmd_mem_en is 1. With cmd_mem_en at 0 every memory request reports a miss.
- R2: An I/O request (req_is_io=1) is claimed only by I/O windows, and only while cmd_io_en is 1. A memory request never hits an I/O window.
- R3: The ROM window, reported as index NSLOT (6 by default), matches only when cmd_mem_en is 1 and bit 0 of rom_reg is 1. Its size is 2^ROM_LOG2 bytes.
- R4: A window of size 2^N claims base through base+2^N-1 and nothing outside that range. The base is the register value with bits below N ignored. res_offset is the request address minus the base.
- R5: A 64-bit window at slot i compares all 64 address bits. Bits [31:0] of the base come from slot i and bits [63:32] come from slot i+1.
- R6: A 32-bit memory window, an I/O window or the ROM window never claims an address that has any bit in [63:32] set.
- R7: When several windows match, the lowest index is reported. The ROM window has the lowest priority.
- R8: res_valid is 1 in the cycle after each cycle with req_valid=1 and 0 otherwise, and back-to-back requests each give one result. After reset every output is 0.
- R9: While res_valid is 1, exactly one of res_hit and res_miss is 1. On a miss, and whenever res_valid is 0, res_index and res_offset are 0.
- R10: A slot of kind empty, including the upper half of a 64-bit window, never matches on its own, whatever value it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 64 | Request address |
| req_is_io | input | 1 | 1 = I/O space request, 0 = memory space request |
| cmd_mem_en | input | 1 | Command register memory space enable |
| cmd_io_en | input | 1 | Command register I/O space enable |
| slot_regs | input | NSLOT*32 | Programmed slot register values, slot i at bits [32i+31:32i] |
| rom_reg | input | 32 | Option-ROM register, bit 0 is its enable |
| res_valid | output | 1 | Result strobe, one cycle after req_valid |
| res_hit | output | 1 | Address claimed |
| res_miss | output | 1 | Address not claimed |
| res_index | output | $clog2(NSLOT+1) | Winning slot, NSLOT for the ROM |
| res_offset | output | 64 | Byte offset inside the winning window |

## Verification
A wrong mask or base select inside a slot comparator shows up as a wrong hit, a wrong index or a wrong offset. It appears on the very next result, but only for an address that sits near that window's edges, so every window is probed at its first byte, its last byte and one byte past it. A fault in the enable gating or the space separation shows as a hit where the bench expects a miss, again one cycle after the request. Overlapping windows and a ROM overlapping a slot expose priority faults in the reported index. Back-to-back requests show any register or strobe fault as a lost or shifted result.

// File: rtl/claim_pkg.sv
package claim_pkg;

   // 2-bit per-slot code used in the SLOT_KINDS parameter vector
   localparam logic [1:0] CODE_NONE  = 2'd0;
   localparam logic [1:0] CODE_MEM32 = 2'd1;
   localparam logic [1:0] CODE_MEM64 = 2'd2;
   localparam logic [1:0] CODE_IO    = 2'd3;

   typedef enum logic [2:0] {
      MK_NONE  = 3'd0,
      MK_MEM32 = 3'd1,
      MK_MEM64 = 3'd2,
      MK_IO    = 3'd3,
      MK_ROM   = 3'd4
   } match_kind_e;

   function automatic match_kind_e code_to_kind(input logic [1:0] code);
      case (code)
         CODE_MEM32: return MK_MEM32;
         CODE_MEM64: return MK_MEM64;
         CODE_IO:    return MK_IO;
         default:    return MK_NONE;
      endcase
   endfunction

   // Mask that keeps address bits at and above lg
   function automatic logic [63:0] keep_mask(input int lg);
      return ~((64'd1 << lg) - 64'd1);
   endfunction

endpackage

// File: rtl/claim_region_match.sv
module claim_region_match
   import claim_pkg::*;
#(
   parameter match_kind_e KIND = MK_NONE,
   parameter int          LOG2 = 12
) (
   input  logic [63:0] addr,
   input  logic        is_io,
   input  logic        mem_en,
   input  logic        io_en,
   input  logic [31:0] lo_reg,
   input  logic [31:0] hi_reg,
   output logic        match,
   output logic [63:0] offset
);

   localparam logic [63:0] KEEP = keep_mask(LOG2);

   logic [63:0] base;
   logic        space_ok;

   always_comb begin
      base = (KIND == MK_MEM64) ? {hi_reg, lo_reg} : {32'h0, lo_reg};
      case (KIND)
         MK_MEM32, MK_MEM64: space_ok = !is_io && mem_en;
         MK_IO:              space_ok = is_io && io_en;
         MK_ROM:             space_ok = !is_io && mem_en && lo_reg[0];
         default:            space_ok = 1'b0;
      endcase
      match  = space_ok && (((addr ^ base) & KEEP) == 64'd0);
      offset = addr & ~KEEP;
   end

endmodule

// File: rtl/claim_lowest_pick.sv
module claim_lowest_pick #(
   parameter int N  = 7,
   parameter int IW = 3
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (req[k]) begin
            found = 1'b1;
            idx   = IW'(k);
         end
      end
   end

endmodule

// File: rtl/addr_claim_decoder.sv
module addr_claim_decoder
   import claim_pkg::*;
#(
   parameter int                 NSLOT      = 6,
   parameter logic [NSLOT*2-1:0] SLOT_KINDS = 12'h12D,
   parameter logic [NSLOT*8-1:0] SLOT_LOG2  = 48'h0010_001A_080C,
   parameter int                 ROM_LOG2   = 15,
   localparam int                IDX_W      = $clog2(NSLOT + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [63:0]        req_addr,
   input  logic               req_is_io,
   input  logic               cmd_mem_en,
   input  logic               cmd_io_en,
   input  logic [NSLOT*32-1:0] slot_regs,
   input  logic [31:0]        rom_reg,
   output logic               res_valid,
   output logic               res_hit,
   output logic               res_miss,
   output logic [IDX_W-1:0]   res_index,
   output logic [63:0]        res_offset
);

   localparam int NWIN = NSLOT + 1;

   if (ROM_LOG2 < 11 || ROM_LOG2 > 31) begin : g_bad_rom
      $error("ROM_LOG2 must lie in 11..31");
   end

   logic [NWIN-1:0] win_hit;
   logic [63:0]     win_off [NWIN];

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      localparam match_kind_e K  = code_to_kind(SLOT_KINDS[2*i +: 2]);
      localparam int          LG = int'(SLOT_LOG2[8*i +: 8]);
      logic [31:0] hi_word;

      if (K == MK_MEM64 && ((i % 2) != 0 || i == NSLOT - 1)) begin : g_bad_pair
         $error("64-bit window must start on an even slot with a slot after it");
      end
      if ((K == MK_MEM32 && (LG < 4 || LG > 31)) ||
          (K == MK_MEM64 && (LG < 4 || LG > 63)) ||
          (K == MK_IO && (LG < 2 || LG > 31))) begin : g_bad_size
         $error("slot size exponent out of range for its kind");
      end

      if (i + 1 < NSLOT) begin : g_hi
         assign hi_word = slot_regs[32*(i+1) +: 32];
         if (K == MK_MEM64 && SLOT_KINDS[2*(i+1) +: 2] != CODE_NONE) begin : g_bad_upper
            $error("slot after a 64-bit window must be coded empty");
         end
      end else begin : g_hi0
         assign hi_word = 32'h0;
      end

      claim_region_match #(.KIND(K), .LOG2(LG)) u_match (
         .addr   (req_addr),
         .is_io  (req_is_io),
         .mem_en (cmd_mem_en),
         .io_en  (cmd_io_en),
         .lo_reg (slot_regs[32*i +: 32]),
         .hi_reg (hi_word),
         .match  (win_hit[i]),
         .offset (win_off[i])
      );
   end

   claim_region_match #(.KIND(MK_ROM), .LOG2(ROM_LOG2)) u_rom (
      .addr   (req_addr),
      .is_io  (req_is_io),
      .mem_en (cmd_mem_en),
      .io_en  (cmd_io_en),
      .lo_reg (rom_reg),
      .hi_reg (32'h0),
      .match  (win_hit[NSLOT]),
      .offset (win_off[NSLOT])
   );

   logic             any_hit;
   logic [IDX_W-1:0] win_idx;
   logic [63:0]      sel_off;

   claim_lowest_pick #(.N(NWIN), .IW(IDX_W)) u_pick (
      .req   (win_hit),
      .found (any_hit),
      .idx   (win_idx)
   );

   always_comb begin
      sel_off = 64'd0;
      for (int k = 0; k < NWIN; k++) begin
         if (win_idx == IDX_W'(k)) sel_off = win_off[k];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_hit    <= 1'b0;
         res_miss   <= 1'b0;
         res_index  <= '0;
         res_offset <= 64'd0;
      end else begin
         res_valid  <= req_valid;
         res_hit    <= req_valid && any_hit;
         res_miss   <= req_valid && !any_hit;
         res_index  <= (req_valid && any_hit) ? win_idx : '0;
         res_offset <= (req_valid && any_hit) ? sel_off : 64'd0;
      end
   end

endmodule

// File: rtl/claim_checker.sv
module claim_checker #(
   parameter int IDX_W   = 3,
   parameter int ROM_IDX = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [31:0]      req_addr_hi,
   input logic             req_is_io,
   input logic             cmd_mem_en,
   input logic             cmd_io_en,
   input logic             rom_en_bit,
   input logic             res_valid,
   input logic             res_hit,
   input logic             res_miss,
   input logic [IDX_W-1:0] res_index
);

   AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid); // R8
   AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid); // R8
   AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_hit ^ res_miss)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_hit && !res_miss && res_index == '0)); // R9
   AST_MEM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_is_io && !cmd_mem_en) |=> res_miss); // R1
   AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_io && !cmd_io_en) |=> res_miss); // R2
   AST_ROM_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rom_en_bit) |=> !(res_hit && res_index == IDX_W'(ROM_IDX))); // R3
   AST_IO_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_is_io && req_addr_hi != 32'h0) |=> res_miss); // R6
   AST_ROM_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_addr_hi != 32'h0) |=> !(res_hit && res_index == IDX_W'(ROM_IDX))); // R6
   AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_index <= IDX_W'(ROM_IDX)); // R7

endmodule

bind addr_claim_decoder claim_checker #(.IDX_W(IDX_W), .ROM_IDX(NSLOT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_addr_hi (req_addr[63:32]),
   .req_is_io   (req_is_io),
   .cmd_mem_en  (cmd_mem_en),
   .cmd_io_en   (cmd_io_en),
   .rom_en_bit  (rom_reg[0]),
   .res_valid   (res_valid),
   .res_hit     (res_hit),
   .res_miss    (res_miss),
   .res_index   (res_index)
);

// File: tb/sim_addr_claim_decoder.sv
`timescale 1ns/1ps
module sim_addr_claim_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = 64'd0;
   logic        req_is_io = 1'b0;
   logic        cmd_mem_en = 1'b0;
   logic        cmd_io_en = 1'b0;
   logic [31:0] r0 = 0, r1 = 0, r2 = 0, r3 = 0, r4 = 0, r5 = 0, rom = 0;
   logic        res_valid, res_hit, res_miss;
   logic [2:0]  res_index;
   logic [63:0] res_offset;

   always #2 clk = ~clk;

   // Layout: 0 mem32 4KB, 1 io 256B, 2+3 mem64 64MB, 4 mem32 64KB, 5 empty, ROM 32KB
   addr_claim_decoder #(
      .NSLOT(6), .SLOT_KINDS(12'h12D), .SLOT_LOG2(48'h0010_001A_080C), .ROM_LOG2(15)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_is_io(req_is_io), .cmd_mem_en(cmd_mem_en), .cmd_io_en(cmd_io_en),
      .slot_regs({r5, r4, r3, r2, r1, r0}), .rom_reg(rom),
      .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
      .res_index(res_index), .res_offset(res_offset)
   );

   typedef struct {
      logic        hit;
      logic [2:0]  idx;
      logic [63:0] off;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   fails = 0;
   bit   done = 0;

   function automatic exp_t model(input logic [63:0] a, input logic io, input string tag);
      exp_t e;
      logic [6:0] m;
      logic [63:0] offs [7];
      m = '0;
      m[0] = !io && cmd_mem_en && a[63:32] == 0 && a[31:12] == r0[31:12];
      m[1] = io && cmd_io_en && a[63:32] == 0 && a[31:8] == r1[31:8];
      m[2] = !io && cmd_mem_en && a[63:26] == {r3, r2[31:26]};
      m[4] = !io && cmd_mem_en && a[63:32] == 0 && a[31:16] == r4[31:16];
      m[6] = !io && cmd_mem_en && rom[0] && a[63:32] == 0 && a[31:15] == rom[31:15];
      offs[0] = a & 64'hFFF;     offs[1] = a & 64'hFF;
      offs[2] = a & 64'h3FF_FFFF; offs[3] = 0;
      offs[4] = a & 64'hFFFF;    offs[5] = 0;
      offs[6] = a & 64'h7FFF;
      e.hit = 0; e.idx = 0; e.off = 0; e.tag = tag;
      for (int k = 6; k >= 0; k--) begin
         if (m[k]) begin e.hit = 1; e.idx = 3'(k); e.off = offs[k]; end
      end
      return e;
   endfunction

   task automatic issue(input logic [63:0] a, input logic io, input string tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      req_is_io = io;
      exp_q.push_back(model(a, io, tag));
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: pops the scoreboard whenever a result appears
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R8 result without request: actual res_valid=1 expected 0");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (res_hit !== e.hit || res_miss !== !e.hit || res_index !== e.idx || res_offset !== e.off) begin
               fails++;
               $display("FAIL %s: actual hit=%0b miss=%0b idx=%0d off=%h expected hit=%0b miss=%0b idx=%0d off=%h",
                        e.tag, res_hit, res_miss, res_index, res_offset, e.hit, !e.hit, e.idx, e.off);
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (res_valid !== 0 || res_hit !== 0 || res_miss !== 0 || res_index !== 0 || res_offset !== 0) begin
         fails++;
         $display("FAIL R8 reset state: actual v=%0b h=%0b m=%0b expected all 0", res_valid, res_hit, res_miss);
      end

      r0 = 32'hF900_0000; r1 = 32'h0000_4001; r2 = 32'h4000_000C; r3 = 32'h0000_0002;
      r4 = 32'hF900_0000; r5 = 32'h0; rom = 32'h000C_0000;

      issue(64'hF900_0000, 0, "R1 mem disabled");
      issue(64'h0000_4000, 1, "R2 io disabled");
      idle();
      cmd_mem_en = 1;
      issue(64'hF900_0000, 0, "R7 overlap lowest slot");
      issue(64'hF900_0FFF, 0, "R4 last byte");
      issue(64'hF900_1000, 0, "R4 next window");
      issue(64'hF901_0000, 0, "R4 past end");
      issue(64'hF8FF_FFFF, 0, "R4 below base");
      issue(64'h0000_4000, 0, "R2 mem req to io window");
      issue(64'h0000_4080, 1, "R2 io still disabled");
      idle();
      cmd_io_en = 1;
      issue(64'h0000_4080, 1, "R2 io hit");
      issue(64'h0000_40FF, 1, "R4 io last byte");
      issue(64'h0000_4100, 1, "R4 io past end");
      issue(64'hF900_0000, 1, "R2 io req to mem window");
      issue(64'h1_0000_4000, 1, "R6 io high addr");
      issue(64'h2_4000_0000, 0, "R5 pair base");
      issue(64'h2_43FF_FFFF, 0, "R5 pair last byte");
      issue(64'h0_4000_0000, 0, "R5 upper word mismatch");
      issue(64'h3_4000_0000, 0, "R5 upper word mismatch");
      issue(64'h1_F900_0000, 0, "R6 mem32 high addr");
      issue(64'h000C_0010, 0, "R3 rom disabled");
      idle();
      rom = 32'h000C_0001;
      issue(64'h000C_0010, 0, "R3 rom hit");
      issue(64'h000C_7FFF, 0, "R3 rom last byte");
      issue(64'h1_000C_0010, 0, "R6 rom high addr");
      issue(64'h000C_0010, 1, "R3 io req to rom");
      idle();
      cmd_mem_en = 0;
      issue(64'h000C_0010, 0, "R3 rom needs mem enable");
      issue(64'h2_4000_0000, 0, "R1 pair gated");
      idle();
      cmd_mem_en = 1;
      r4 = 32'h000C_0000;
      r5 = 32'hFFFF_FFFF;
      issue(64'h000C_0010, 0, "R7 slot beats rom");
      issue(64'hFFFF_FF00, 0, "R10 empty slot");
      issue(64'h0000_0002_0000_0000, 0, "R10 upper half alone");
      idle();
      repeat (4) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R8 lost results: actual pending=%0d expected 0", exp_q.size());
      end
      checks++;
      if (res_valid !== 0 || res_miss !== 0) begin
         fails++;
         $display("FAIL R9 idle outputs: actual v=%0b m=%0b expected 0 0", res_valid, res_miss);
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule